// File: doc/BRIEF.md
# PWM-Locked ADC Convert-Start Generator

This block produces a one-clock convert-start strobe for an analog-to-digital converter, with a period that is a programmable number of input clocks. When synchronization is enabled, every pulse from the PWM generator's period-sync output restarts the ADC period counter. The ADC cadence therefore stays phase-locked to the PWM switching cycle, even when the ADC period is an integer fraction of the PWM period, so that several strobes fall in each PWM period.

In single-update PWM mode, a 7-bit phase value divides the ADC period into 128 slices. The strobe is then delayed after each realignment by (128 − phase)/128 of the ADC period. A phase of zero means no delay. Outside that mode, and whenever synchronization is off, the strobe falls at the start of each period. With synchronization off, the counter runs freely and ignores the sync input.

New divider and phase values are taken only at the start of a period: either when the counter wraps or when a realigning sync pulse arrives. A change in the middle of a period therefore cannot produce a doubled or lost strobe. A divider value of zero stops the strobes.

Top module: `cvst_gen`

## Requirements
- R1: While reset is asserted, and in the first clock after reset is released, `cnv_start_o` is 0.
- R2: When either bit of `sync_en_i` is 0, strobes repeat every `div_i` clocks and pulses on `pwm_sync_i` have no effect on their timing.
- R3: When `sync_en_i` is 2'b11 and the lag is zero, a `pwm_sync_i` pulse sampled at clock edge E restarts the period. The strobe is high in the cycle that follows E, and then repeats every `div_i` clocks.
- R4: When synchronization is on, `single_upd_i` is 1 and `phase_i` = p is not 0, the strobe follows the realigning edge by ((128 − p) × div) >> 7 clocks. For example, div 384 with p 96 gives 96 clocks.
- R5: A `phase_i` value of 0 gives zero lag, even in single-update mode.
- R6: When `single_upd_i` is 0, `phase_i` has no effect and the lag is zero.
- R7: With the ADC period an integer fraction of the PWM sync period, each sync period holds that many strobes. The lag is measured in ADC-period slices.
- R8: `div_i` and `phase_i` are sampled only at a period start, which is a counter wrap or a realigning sync. A change in the middle of a period leaves the current period's length unchanged.
- R9: While the sampled divider is 0, no strobe is produced. A nonzero value written afterwards starts strobing at that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_sync_i | input | 1 | PWM period-sync pulse |
| div_i | input | DIV_W | ADC period in clocks (0 stops strobes) |
| phase_i | input | 7 | Phase slice count, 128 slices per period |
| sync_en_i | input | 2 | Both bits set enable realignment to the PWM sync |
| single_upd_i | input | 1 | PWM single-update mode; enables the phase lag |
| cnv_start_o | output | 1 | One-clock convert-start strobe |

## Verification
The assertions check four properties on every cycle:
- no strobe while the divider is zero;
- the computed lag always lies inside the period;
- a realigning sync always restarts the counter, while an ignored sync leaves it counting;
- the divider and lag registers never change away from a period start.

Only the bench scenarios can show the things that depend on arithmetic and on long stretches of time:
- the exact lag produced by given phase values;
- the number of strobes in each PWM period when the rates differ;
- the gap lengths around a mid-period divider change.

// File: rtl/cvst_pkg.sv
package cvst_pkg;
  // Lag in clocks from a period start to the strobe.
  // slot_bits: phase width; period * 2^slot_bits must fit in 32 bits.
  function automatic logic [31:0] lag_clocks(input logic [31:0] period,
                                             input logic [31:0] slot,
                                             input int unsigned slot_bits,
                                             input logic        phased);
    logic [31:0] lead;
    logic [31:0] prod;
    if (!phased || slot == 32'd0) return 32'd0;
    lead = (32'd1 << slot_bits) - slot;
    prod = lead * period;
    return prod >> slot_bits;
  endfunction
endpackage

// File: rtl/cvst_lag_calc.sv
module cvst_lag_calc #(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned PH_W  = 7
) (
  input  logic [DIV_W-1:0] div_i,
  input  logic [PH_W-1:0]  phase_i,
  input  logic             phased_i,
  output logic [DIV_W-1:0] lag_o
);
  // The lag never exceeds div-1, so truncation to DIV_W bits is lossless.
  assign lag_o = DIV_W'(cvst_pkg::lag_clocks(32'(div_i), 32'(phase_i), PH_W, phased_i));
endmodule

// File: rtl/cvst_period_timer.sv
module cvst_period_timer #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [DIV_W-1:0] lag_i,
  output logic [DIV_W-1:0] cnt_o,
  output logic [DIV_W-1:0] div_o,
  output logic [DIV_W-1:0] lag_o,
  output logic             start_o,
  output logic             fire_o
);
  logic [DIV_W-1:0] cnt_q, div_q, lag_q;
  logic [DIV_W:0]   cnt_inc;
  logic             wrap;

  // A zero divider wraps every cycle, so a new value is picked up at once.
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign wrap    = (cnt_inc >= {1'b0, div_q});
  assign start_o = restart_i | wrap;
  assign fire_o  = (div_q != '0) && (cnt_q == lag_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= '0;
      lag_q <= '0;
    end else if (start_o) begin
      cnt_q <= '0;
      div_q <= div_i;
      lag_q <= lag_i;
    end else begin
      cnt_q <= cnt_inc[DIV_W-1:0];
    end
  end

  assign cnt_o = cnt_q;
  assign div_o = div_q;
  assign lag_o = lag_q;
endmodule

// File: rtl/cvst_gen.sv
module cvst_gen #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_sync_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [6:0]       phase_i,
  input  logic [1:0]       sync_en_i,
  input  logic             single_upd_i,
  output logic             cnv_start_o
);
  localparam int unsigned PH_W = 7;

  logic             sync_on;
  logic             realign;
  logic             phased;
  logic [DIV_W-1:0] lag_nx;
  logic [DIV_W-1:0] cnt_q, div_q, lag_q;
  logic             period_start;
  logic             fire;

  assign sync_on = &sync_en_i;
  assign realign = sync_on & pwm_sync_i;
  assign phased  = sync_on & single_upd_i;

  cvst_lag_calc #(.DIV_W(DIV_W), .PH_W(PH_W)) u_lag (
    .div_i    (div_i),
    .phase_i  (phase_i),
    .phased_i (phased),
    .lag_o    (lag_nx)
  );

  cvst_period_timer #(.DIV_W(DIV_W)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (realign),
    .div_i     (div_i),
    .lag_i     (lag_nx),
    .cnt_o     (cnt_q),
    .div_o     (div_q),
    .lag_o     (lag_q),
    .start_o   (period_start),
    .fire_o    (fire)
  );

  assign cnv_start_o = fire;
endmodule

// File: rtl/cvst_gen_chk.sv
module cvst_gen_chk #(
  parameter int unsigned DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_on,
  input logic             pwm_sync_i,
  input logic             period_start,
  input logic [DIV_W-1:0] cnt_q,
  input logic [DIV_W-1:0] div_q,
  input logic [DIV_W-1:0] lag_q,
  input logic             cnv_start_o
);
  a_r9_idle_when_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == '0) |-> !cnv_start_o);

  a_r4_lag_inside_period: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q != '0) |-> (lag_q < div_q));

  a_r3_sync_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_on && pwm_sync_i) |=> (cnt_q == '0));

  a_r2_sync_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_on && pwm_sync_i && !period_start && div_q != '0)
      |=> (cnt_q == $past(cnt_q) + 1'b1));

  a_r8_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start |=> ($stable(div_q) && $stable(lag_q)));
endmodule

bind cvst_gen cvst_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sync_on      (sync_on),
  .pwm_sync_i   (pwm_sync_i),
  .period_start (period_start),
  .cnt_q        (cnt_q),
  .div_q        (div_q),
  .lag_q        (lag_q),
  .cnv_start_o  (cnv_start_o)
);

// File: tb/cvst_gen_test.sv
module cvst_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwm_sync = 1'b0;
  logic [15:0] div = '0;
  logic [6:0]  phase = '0;
  logic [1:0]  sync_en = '0;
  logic        single_upd = 1'b0;
  wire         strobe;

  int    checks = 0;
  int    errs = 0;
  string cur_req = "R1";
  bit    done = 0;

  always #2 clk = ~clk;

  cvst_gen #(.DIV_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .pwm_sync_i(pwm_sync), .div_i(div),
    .phase_i(phase), .sync_en_i(sync_en), .single_upd_i(single_upd),
    .cnv_start_o(strobe)
  );

  // Behavioural reference: where in the ADC period we are, how long it is, where the strobe sits.
  int  m_pos = 0, m_len = 0, m_lag = 0;
  bit  expect_strobe = 0;
  always @(posedge clk) begin
    bit locked, boundary;
    locked   = (sync_en == 2'b11);
    boundary = (locked && pwm_sync) || m_len == 0 || m_pos + 1 >= m_len;
    if (!rst_n) begin
      m_pos = 0; m_len = 0; m_lag = 0;
    end else if (boundary) begin
      m_len = int'(div);
      if (locked && single_upd && phase != 0)
        m_lag = ((128 - int'(phase)) * m_len) / 128;
      else
        m_lag = 0;
      m_pos = 0;
    end else begin
      m_pos++;
    end
    expect_strobe = (m_len != 0) && (m_pos == m_lag);
  end

  // Per-clock comparison plus gap and count bookkeeping.
  int cyc = 0, last_hit = -1, strobe_cnt = 0;
  int gaps[$];
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (strobe !== (rst_n ? expect_strobe : 1'b0)) begin
        errs++;
        $display("FAIL %s: cnv_start=%0b expected %0b at cycle %0d", cur_req, strobe,
                 rst_n ? expect_strobe : 1'b0, cyc);
      end
      if (strobe === 1'b1) begin
        strobe_cnt++;
        if (last_hit >= 0) gaps.push_back(cyc - last_hit);
        last_hit = cyc;
      end
      cyc++;
    end
  end

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic pulse();
    pwm_sync = 1'b1; step(1); pwm_sync = 1'b0;
  endtask

  // Clocks from the sampling edge of a sync pulse to the strobe.
  task automatic lag_after_pulse(output int k);
    pulse();
    k = 0;
    @(negedge clk);
    while (strobe !== 1'b1 && k < 5000) begin k++; @(negedge clk); end
    @(posedge clk); #1;
  endtask

  task automatic summary();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
  endtask

  initial begin
    #(4 * 150000);
    errs++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    int k;
    // R1: reset state
    step(5);
    check("R1", int'(strobe), 0, "strobe during reset");
    rst_n = 1'b1;
    div = 16'd10; sync_en = 2'b01; single_upd = 1'b1; phase = 7'd32;
    check("R1", int'(strobe), 0, "strobe right after reset");

    // R2: free running, sync ignored, on either half-enable
    cur_req = "R2";
    step(30);
    gaps.delete();
    repeat (5) begin step(7); pulse(); end
    step(12);
    foreach (gaps[i]) check("R2", gaps[i], 10, "free-run gap (en=01)");
    sync_en = 2'b10;
    step(20); gaps.delete();
    repeat (4) begin step(3); pulse(); end
    step(10);
    check("R2", gaps.size() > 0 ? gaps[0] : -1, 10, "free-run gap (en=10)");

    // R3: realign with zero lag
    cur_req = "R3";
    sync_en = 2'b11; single_upd = 1'b0; div = 16'd40; phase = 7'd0;
    step(5);
    lag_after_pulse(k);
    check("R3", k, 0, "lag after sync");
    gaps.delete(); step(85);
    check("R3", gaps.size() > 0 ? gaps[0] : -1, 40, "gap after realign");

    // R4: phase lag in single-update mode
    cur_req = "R4";
    single_upd = 1'b1; div = 16'h180; phase = 7'h60;
    lag_after_pulse(k);
    check("R4", k, 96, "lag div=0x180 phase=0x60");
    div = 16'd100; phase = 7'd1;
    lag_after_pulse(k);
    check("R4", k, 99, "lag div=100 phase=1");
    div = 16'd200; phase = 7'd127;
    lag_after_pulse(k);
    check("R4", k, 1, "lag div=200 phase=127");

    // R5: phase zero means no lag
    cur_req = "R5";
    phase = 7'd0; div = 16'd64;
    lag_after_pulse(k);
    check("R5", k, 0, "lag with phase 0");

    // R6: phase ignored outside single-update mode
    cur_req = "R6";
    single_upd = 1'b0; phase = 7'h60; div = 16'h180;
    lag_after_pulse(k);
    check("R6", k, 0, "lag without single update");

    // R7: ADC rate = 3x PWM rate with lag 10 (div 20, phase 64)
    cur_req = "R7";
    single_upd = 1'b1; div = 16'd20; phase = 7'd64;
    pulse(); strobe_cnt = 0;
    for (int i = 0; i < 3; i++) begin
      step(59); pulse();
      check("R7", strobe_cnt, 3, "strobes per PWM period");
      strobe_cnt = 0;
    end
    lag_after_pulse(k);
    check("R7", k, 10, "lag in ADC slices");

    // R8: divider change mid-period takes effect at next start
    cur_req = "R8";
    sync_en = 2'b00; div = 16'd50;
    step(120);
    @(negedge clk);
    while (strobe !== 1'b1) @(negedge clk);
    @(posedge clk); #1;
    gaps.delete();
    step(20); div = 16'd20; step(100);
    check("R8", gaps.size() > 0 ? gaps[0] : -1, 50, "gap of period in flight");
    check("R8", gaps.size() > 1 ? gaps[1] : -1, 20, "gap after reload");

    // R9: zero divider stops strobes, nonzero resumes
    cur_req = "R9";
    div = 16'd0; step(60);
    strobe_cnt = 0; step(100);
    check("R9", strobe_cnt, 0, "strobes with div 0");
    div = 16'd7; gaps.delete(); step(40);
    check("R9", gaps.size() > 0 ? gaps[gaps.size()-1] : -1, 7, "gap after restart");

    // R8: mixed random stimulus, compared per clock against the model
    cur_req = "R8";
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 15) == 0) div = 16'($urandom_range(0, 40));
      if ($urandom_range(0, 15) == 0) phase = 7'($urandom_range(0, 127));
      if ($urandom_range(0, 31) == 0) sync_en = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 31) == 0) single_upd = ~single_upd;
      pwm_sync = ($urandom_range(0, 24) == 0);
      step(1);
    end
    pwm_sync = 1'b0;
    step(5);
    summary();
    $finish;
  end
endmodule